// File: doc/BRIEF.md
# DRAM Refresh and Bring-Up Sequencer

This block keeps an asynchronous DRAM's contents alive and prepares it for use after power is applied. It first waits a fixed settling time and then runs a counted series of warm-up refresh cycles. After that it raises `ready`, and the access controller may start normal traffic.

Once `ready` is high, an interval timer adds one to a count of owed refreshes every `INTERVAL_CYC` clocks. While that count is non-zero, the block raises `bus_req`. When `bus_grant` comes back, it runs one refresh in the order that needs no row address: the column strobe falls first, then the row strobe falls, then the strobes are released. The row strobe then rests high for a precharge time before the next cycle may begin.

The owed count saturates at `OWED_MAX`. The access controller can therefore hold off a grant for several intervals without losing any refresh. Every timing value is a parameter counted in clock cycles. Address, write-enable and output-enable are left to the access controller, because this kind of refresh ignores them.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n` and `cas_n` are 1, and `bus_req`, `ready` and `owed_cnt` are 0.
- R2: A two-stage reset synchronizer releases the internal reset. `bus_req` stays 0 until the clock edge `STARTUP_CYC`+2 after `rst_n` rises, and it is 1 from that edge on.
- R3: Each refresh cycle follows a fixed order.
  - `cas_n`=0 with `ras_n`=1 for `CSR_CYC` cycles.
  - Then both are 0 for `CHR_CYC` cycles.
  - Then `ras_n`=0 with `cas_n`=1 for `HOLD_CYC` cycles.
  - Then both are 1 for at least `RP_CYC` cycles before `cas_n` falls again.
  - `ras_n` never falls while `cas_n` is 1.
- R4: A refresh cycle starts only from idle, with `cas_n` falling one clock after an edge that sees `bus_req`=1 and `bus_grant`=1. While `bus_grant` is 0, no new cycle starts.
- R5: `ready` rises on the clock edge that completes the `INIT_CYCLES`-th warm-up cycle, and it then stays 1 until reset.
- R6: While `ready` is 1, `owed_cnt` increases by one every `INTERVAL_CYC` cycles. The first increase comes `INTERVAL_CYC` edges after `ready` rises. While `ready` is 0, `owed_cnt` is 0.
- R7: `owed_cnt` saturates at `OWED_MAX`. Interval expiries at the limit are dropped.
- R8: After warm-up, `bus_req` is 1 exactly while `owed_cnt` is non-zero or a refresh cycle is in progress. Each completed refresh lowers `owed_cnt` by one.
- R9: If an interval expiry and a refresh completion fall on the same edge, `owed_cnt` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 1 | Access controller hands the DRAM strobes to this block |
| bus_req | output | 1 | Request for the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Bring-up finished; normal access allowed |
| owed_cnt | output | OWED_W | Refreshes due but not yet run (OWED_W = clog2(OWED_MAX+1)) |

## Verification
The assertions watch the strobe ordering, the rule that a cycle starts only after a grant, the saturation bound, the one-step change in the owed count, and that `ready` stays high once set. They check these on every cycle, whatever the grant pattern. Three things need the bench scenarios because they depend on exact clock counts:
- the dwell length of each strobe phase, and the edge where the settling time ends;
- the edge where `ready` rises, and the interval period;
- the outcome when an interval expiry lands on a completion edge, and the drain of a saturated backlog when the grant returns late.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  // Strobe sequencer states, in the order one refresh cycle visits them
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SETUP  = 3'd1,
    SQ_STROBE = 3'd2,
    SQ_HOLD   = 3'd3,
    SQ_PRECH  = 3'd4
  } strobe_state_e;

  // Bring-up phases
  typedef enum logic [1:0] {
    PH_SETTLE = 2'd0,
    PH_WARMUP = 2'd1,
    PH_LIVE   = 2'd2
  } bring_up_e;

endpackage

// File: rtl/refseq_rst_sync.sv
module refseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/refseq_bringup.sv
module refseq_bringup
  import refseq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 10000,
  parameter int unsigned WARMUP_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_done,
  output logic warmup_active,
  output logic ready
);

  localparam int unsigned SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int unsigned WW = $clog2(WARMUP_CNT + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
  localparam logic [WW-1:0] WARM_LAST   = WW'(WARMUP_CNT - 1);

  bring_up_e         phase_q, phase_d;
  logic [SW-1:0]     settle_q, settle_d;
  logic [WW-1:0]     warm_q, warm_d;

  always_comb begin
    phase_d  = phase_q;
    settle_d = settle_q;
    warm_d   = warm_q;
    case (phase_q)
      PH_SETTLE: begin
        if (settle_q == SETTLE_LAST) begin
          phase_d = PH_WARMUP;
        end else begin
          settle_d = settle_q + 1'b1;
        end
      end
      PH_WARMUP: begin
        if (cycle_done) begin
          if (warm_q == WARM_LAST) begin
            phase_d = PH_LIVE;
          end else begin
            warm_d = warm_q + 1'b1;
          end
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_SETTLE;
      settle_q <= '0;
      warm_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_SETTLE) begin
        settle_q <= settle_d;
      end
      if (phase_q == PH_WARMUP && cycle_done) begin
        warm_q <= warm_d;
      end
    end
  end

  assign warmup_active = (phase_q == PH_WARMUP);
  assign ready         = (phase_q == PH_LIVE);

endmodule

// File: rtl/refseq_interval.sv
module refseq_interval #(
  parameter int unsigned PERIOD_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);

  localparam int unsigned PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (enable) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (enable) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/refseq_owed.sv
module refseq_owed #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add,
  input  logic          sub,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] count_q, count_d;
  logic          at_full, at_empty, grow, shrink;

  assign at_full  = (count_q == FULL);
  assign at_empty = (count_q == '0);
  assign shrink   = sub && !at_empty;
  // at the limit a new expiry is kept only when a completion frees a slot
  assign grow     = add && (!at_full || shrink);

  always_comb begin
    count_d = count_q;
    if (grow && !shrink) begin
      count_d = count_q + 1'b1;
    end else if (shrink && !grow) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (grow ^ shrink) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/refseq_strobe_fsm.sv
module refseq_strobe_fsm
  import refseq_pkg::*;
#(
  parameter int unsigned CSR_CYC  = 1,
  parameter int unsigned CHR_CYC  = 2,
  parameter int unsigned HOLD_CYC = 3,
  parameter int unsigned RP_CYC   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);

  localparam int unsigned M_A     = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
  localparam int unsigned M_B     = (HOLD_CYC > RP_CYC) ? HOLD_CYC : RP_CYC;
  localparam int unsigned LONGEST = (M_A > M_B) ? M_A : M_B;
  localparam int unsigned DW      = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam logic [DW-1:0] L_CSR  = DW'(CSR_CYC - 1);
  localparam logic [DW-1:0] L_CHR  = DW'(CHR_CYC - 1);
  localparam logic [DW-1:0] L_HOLD = DW'(HOLD_CYC - 1);
  localparam logic [DW-1:0] L_RP   = DW'(RP_CYC - 1);

  strobe_state_e st_q, st_d;
  logic [DW-1:0] dw_q, dw_d;
  logic          ras_n_q, cas_n_q;

  always_comb begin
    st_d = st_q;
    dw_d = dw_q;
    done = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (launch) begin
          st_d = SQ_SETUP;
          dw_d = '0;
        end
      end
      SQ_SETUP: begin
        if (dw_q == L_CSR) begin
          st_d = SQ_STROBE;
          dw_d = '0;
        end else begin
          dw_d = dw_q + 1'b1;
        end
      end
      SQ_STROBE: begin
        if (dw_q == L_CHR) begin
          st_d = SQ_HOLD;
          dw_d = '0;
        end else begin
          dw_d = dw_q + 1'b1;
        end
      end
      SQ_HOLD: begin
        if (dw_q == L_HOLD) begin
          st_d = SQ_PRECH;
          dw_d = '0;
        end else begin
          dw_d = dw_q + 1'b1;
        end
      end
      SQ_PRECH: begin
        if (dw_q == L_RP) begin
          st_d = SQ_IDLE;
          dw_d = '0;
          done = 1'b1;
        end else begin
          dw_d = dw_q + 1'b1;
        end
      end
      default: begin
        st_d = SQ_IDLE;
        dw_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      dw_q    <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      dw_q    <= dw_d;
      cas_n_q <= !(st_d == SQ_SETUP || st_d == SQ_STROBE);
      ras_n_q <= !(st_d == SQ_STROBE || st_d == SQ_HOLD);
    end
  end

  assign ras_n = ras_n_q;
  assign cas_n = cas_n_q;
  assign busy  = (st_q != SQ_IDLE);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned STARTUP_CYC  = 10000,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned OWED_MAX     = 8,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned HOLD_CYC     = 3,
  parameter int unsigned RP_CYC       = 5,
  parameter int unsigned RST_STAGES   = 2,
  localparam int unsigned OWED_W      = $clog2(OWED_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              ras_n,
  output logic              cas_n,
  output logic              ready,
  output logic [OWED_W-1:0] owed_cnt
);

  logic rst_n_int;
  logic warmup_active;
  logic live;
  logic interval_tick;
  logic seq_busy, seq_done;
  logic pending, launch;

  refseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  refseq_bringup #(
    .SETTLE_CYC (STARTUP_CYC),
    .WARMUP_CNT (INIT_CYCLES)
  ) u_bringup (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .cycle_done    (seq_done),
    .warmup_active (warmup_active),
    .ready         (live)
  );

  refseq_interval #(.PERIOD_CYC(INTERVAL_CYC)) u_interval (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .enable (live),
    .tick   (interval_tick)
  );

  refseq_owed #(.LIMIT(OWED_MAX), .CW(OWED_W)) u_owed (
    .clk   (clk),
    .rst_n (rst_n_int),
    .add   (interval_tick),
    .sub   (seq_done && live),
    .count (owed_cnt)
  );

  refseq_strobe_fsm #(
    .CSR_CYC  (CSR_CYC),
    .CHR_CYC  (CHR_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RP_CYC   (RP_CYC)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .launch (launch),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .busy   (seq_busy),
    .done   (seq_done)
  );

  assign pending = warmup_active || (owed_cnt != '0);
  assign launch  = pending && bus_grant;
  assign bus_req = pending || seq_busy;
  assign ready   = live;

endmodule

// File: rtl/refseq_checker.sv
module refseq_checker #(
  parameter int unsigned OWED_MAX = 8,
  parameter int unsigned OWED_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_grant,
  input logic              bus_req,
  input logic              ras_n,
  input logic              cas_n,
  input logic              ready,
  input logic [OWED_W-1:0] owed_cnt
);

  // R3
  ras_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R3
  cas_fall_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

  // R4
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ($past(bus_grant) && $past(bus_req)));

  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6
  idle_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (owed_cnt == '0));

  // R7
  owed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt <= OWED_W'(OWED_MAX));

  // R8
  owed_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_cnt != '0) |-> bus_req);

  // R9
  owed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_cnt == $past(owed_cnt)) || (owed_cnt == $past(owed_cnt) + 1'b1) ||
    (owed_cnt == $past(owed_cnt) - 1'b1));

endmodule

bind dram_refresh_seq refseq_checker #(
  .OWED_MAX (OWED_MAX),
  .OWED_W   (OWED_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_grant (bus_grant),
  .bus_req   (bus_req),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .ready     (ready),
  .owed_cnt  (owed_cnt)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;

  localparam int CLK_PERIOD = 10;
  localparam int P_STARTUP  = 16;
  localparam int P_INTERVAL = 40;
  localparam int P_INIT     = 4;
  localparam int P_OWED_MAX = 3;
  localparam int P_CSR      = 1;
  localparam int P_CHR      = 2;
  localparam int P_HOLD     = 2;
  localparam int P_RP       = 3;
  localparam int RST_LAT    = 2;
  localparam int OW         = $clog2(P_OWED_MAX + 1);
  localparam int SEQ_LEN    = P_CSR + P_CHR + P_HOLD + P_RP;
  localparam int EXP_REQ    = P_STARTUP + RST_LAT;
  localparam int EXP_READY  = EXP_REQ + P_INIT * (SEQ_LEN + 1);

  logic          clk, rst_n, bus_grant;
  logic          bus_req, ras_n, cas_n, ready;
  logic [OW-1:0] owed_cnt;

  int checks   = 0;
  int failures = 0;
  int cyc;
  int cbr_count = 0;
  bit finished  = 0;

  dram_refresh_seq #(
    .STARTUP_CYC  (P_STARTUP),
    .INTERVAL_CYC (P_INTERVAL),
    .INIT_CYCLES  (P_INIT),
    .OWED_MAX     (P_OWED_MAX),
    .CSR_CYC      (P_CSR),
    .CHR_CYC      (P_CHR),
    .HOLD_CYC     (P_HOLD),
    .RP_CYC       (P_RP)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_grant (bus_grant),
    .bus_req   (bus_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .ready     (ready),
    .owed_cnt  (owed_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Strobe protocol monitor: run lengths of each {cas_n, ras_n} combination
  logic [1:0] mprev;
  int         mrun;
  bit         seen_cycle;

  always @(negedge clk) begin
    logic [1:0] combo;
    if (!rst_n) begin
      mprev      = 2'b11;
      mrun       = 0;
      seen_cycle = 0;
    end else if (!finished) begin
      combo = {cas_n, ras_n};
      if (combo != mprev) begin
        case (mprev)
          2'b01: begin // R3 setup phase
            check(mrun == P_CSR, "R3 setup length", mrun, P_CSR);
            check(combo == 2'b00, "R3 order after setup", combo, 0);
          end
          2'b00: begin // R3 both strobes low
            check(mrun == P_CHR, "R3 strobe length", mrun, P_CHR);
            check(combo == 2'b10, "R3 order after strobe", combo, 2);
          end
          2'b10: begin // R3 row-only phase
            check(mrun == P_HOLD, "R3 hold length", mrun, P_HOLD);
            check(combo == 2'b11, "R3 order after hold", combo, 3);
            cbr_count++;
          end
          default: begin // idle or precharge ending
            check(combo == 2'b01, "R3 cycle must open with cas", combo, 1);
            if (seen_cycle) check(mrun >= P_RP, "R3 precharge", mrun, P_RP);
            check(bus_grant == 1'b1, "R4 start without grant", bus_grant, 1);
            seen_cycle = 1;
          end
        endcase
        mprev = combo;
        mrun  = 1;
      end else begin
        mrun++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    int base;
    rst_n     = 1'b0;
    bus_grant = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
    check(cas_n == 1'b1, "R1 cas_n", cas_n, 1);
    check(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
    check(ready == 1'b0, "R1 ready", ready, 0);
    check(owed_cnt == 0, "R1 owed_cnt", owed_cnt, 0);
    #1 rst_n = 1'b1;

    // R2 settling delay
    @(negedge clk);
    while (!bus_req && cyc < 1000) @(negedge clk);
    check(cyc == EXP_REQ, "R2 first request", cyc, EXP_REQ);
    // R4 first warm-up cycle opens one clock later
    @(negedge clk);
    check(!cas_n && ras_n, "R4 launch after grant", {cas_n, ras_n}, 1);

    // R5 ready after warm-up
    wait_to(EXP_READY - 1);
    check(ready == 1'b0, "R5 ready early", ready, 0);
    wait_to(EXP_READY);
    check(ready == 1'b1, "R5 ready rise", ready, 1);
    check(cbr_count == P_INIT, "R5 warm-up count", cbr_count, P_INIT);
    check(bus_req == 1'b0, "R8 request after warm-up", bus_req, 0);
    #1 bus_grant = 1'b0;
    r = EXP_READY;

    // R6 interval accumulation with grant withheld
    wait_to(r + P_INTERVAL - 1);
    check(owed_cnt == 0, "R6 before first expiry", owed_cnt, 0);
    wait_to(r + P_INTERVAL);
    check(owed_cnt == 1, "R6 first expiry", owed_cnt, 1);
    wait_to(r + 2 * P_INTERVAL);
    check(owed_cnt == 2, "R6 second expiry", owed_cnt, 2);

    // R7 saturation
    wait_to(r + 4 * P_INTERVAL);
    check(owed_cnt == P_OWED_MAX, "R7 reach limit", owed_cnt, P_OWED_MAX);
    wait_to(r + 5 * P_INTERVAL + 4);
    check(owed_cnt == P_OWED_MAX, "R7 hold at limit", owed_cnt, P_OWED_MAX);
    check(bus_req == 1'b1, "R8 request while owed", bus_req, 1);
    check(ras_n && cas_n, "R4 idle without grant", {cas_n, ras_n}, 3);
    base = cbr_count;

    // R8 drain the backlog
    wait_to(r + 205);
    #1 bus_grant = 1'b1;
    @(negedge clk);
    while (bus_req && cyc < r + 300) @(negedge clk);
    check(cyc == r + 205 + P_OWED_MAX * (SEQ_LEN + 1), "R8 request drop",
          cyc - r, 205 + P_OWED_MAX * (SEQ_LEN + 1));
    check(cbr_count - base == P_OWED_MAX, "R8 cycles run", cbr_count - base, P_OWED_MAX);
    check(owed_cnt == 0, "R8 drained", owed_cnt, 0);
    #1 bus_grant = 1'b0;

    // R9 expiry on a completion edge
    wait_to(r + 6 * P_INTERVAL);
    check(owed_cnt == 1, "R6 expiry after drain", owed_cnt, 1);
    wait_to(r + 7 * P_INTERVAL - SEQ_LEN - 1);
    #1 bus_grant = 1'b1;
    wait_to(r + 7 * P_INTERVAL - SEQ_LEN);
    check(!cas_n && ras_n, "R4 launch timing", {cas_n, ras_n}, 1);
    wait_to(r + 7 * P_INTERVAL);
    check(owed_cnt == 1, "R9 coincident edge", owed_cnt, 1);
    check(bus_req == 1'b1, "R8 request kept", bus_req, 1);
    wait_to(r + 7 * P_INTERVAL + SEQ_LEN + 1);
    check(owed_cnt == 0, "R9 following cycle", owed_cnt, 0);

    // R6 steady state with grant always given
    base = cbr_count;
    wait_to(r + 10 * P_INTERVAL - 5);
    check(cbr_count - base == 2, "R6 periodic cycles", cbr_count - base, 2);
    check(owed_cnt == 0, "R6 steady owed", owed_cnt, 0);
    check(ready == 1'b1, "R5 ready held", ready, 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule